// File: doc/BRIEF.md
# Latency-Configurable Two-Port Synchronous Memory

This block is a word-addressed memory array with two ports on a single clock. The first port can only read. The second port is shared: on each cycle it either writes the array or starts a read, and a mode bit chooses which. Parameters set the word width, the number of words, the size of a write lane, the read latency and the write latency. A further parameter can tie the read port's enable high.

On the read-only port, the address passes through a short register pipeline and then reaches a final read stage. That stage loads only when the matching, equally delayed enable is high. At a read latency of zero, the array is read combinationally from the incoming address. On the shared port, every input is delayed by one cycle less than the write latency. After that delay, the port writes the selected lanes when enable and write mode are both high. When enable is high and write mode is low, it loads its read stage instead. Addresses at or beyond the depth never touch the array. Such a read returns zero and raises a flag.

Top module: `lmem_top`

## Requirements
- R1: With RD_LAT ≥ 1, a read presented on the read-only port with `ra_en` high in cycle c puts the addressed word on `ra_data` in cycle c+RD_LAT. With RD_LAT = 0, the word appears combinationally in cycle c.
- R2: With RD_LAT ≥ 1 and RA_EN_TIED = 0, the read stage holds `ra_data` and `ra_oob` unchanged in every cycle whose delayed enable is low, whatever `ra_addr` carries.
- R3: With RA_EN_TIED = 1, `ra_en` is ignored and the read stage loads the delayed address on every cycle.
- R4: A read at an address ≥ DEPTH returns all zeros with its flag (`ra_oob` or `sp_oob`) high, at the same latency as a normal read. A read of an in-range address drives the flag low.
- R5: On the shared port, a write presented in cycle c updates the array on the clock edge that ends cycle c+WR_LAT−1. Only the lanes whose `sp_wmask` bit is high are written. Mask bit i covers data bits [i·LANE_W +: LANE_W].
- R6: A shared-port cycle with `sp_en` low, or with `sp_wmode` low, leaves the array unchanged.
- R7: With RD_LAT ≥ 1, a shared-port cycle with `sp_en` high and `sp_wmode` low in cycle c puts the addressed word on `sp_rdata` in cycle c+WR_LAT. `sp_rdata` holds its value in every other cycle. With RD_LAT = 0, `sp_rdata` is read combinationally from the incoming `sp_addr`.
- R8: A write to an address ≥ DEPTH changes no word of the array.
- R9: When a read stage loads on the same edge that writes its address, it returns the word as it was before that write.
- R10: While `rst` is high, all pipeline registers and both registered read outputs and flags are zero. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset of pipelines and read stages |
| ra_addr | input | AW | Read-only port address |
| ra_en | input | 1 | Read-only port enable |
| ra_data | output | DATA_W | Read-only port data |
| ra_oob | output | 1 | Read-only port out-of-range flag |
| sp_addr | input | AW | Shared port address |
| sp_en | input | 1 | Shared port enable |
| sp_wmode | input | 1 | Shared port mode: 1 write, 0 read |
| sp_wdata | input | DATA_W | Shared port write data |
| sp_wmask | input | DATA_W/LANE_W | Shared port lane write mask |
| sp_rdata | output | DATA_W | Shared port read data |
| sp_oob | output | 1 | Shared port out-of-range flag |

## Verification
Three copies are driven from the same inputs, so each result has a different due cycle. A zero-latency read is due in the same cycle. A latency-one read or write is due right after the next edge. The default copy with latency two delivers one edge after that, and its shared-port writes land one edge late as well. Stimulus changes on the falling edge and each output is sampled on the falling edge that follows its due rising edge. The default copy is also sampled one cycle early, to show that it does not deliver too soon. After every write, the bench waits three idle cycles before it reads, so that the slowest copy has committed the write.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
package lmem_pkg;

  // number of write lanes in a word
  function automatic int lane_cnt(input int dw, input int lw);
    return (dw + lw - 1) / lw;
  endfunction

  // plain register stages in front of a final read stage
  function automatic int pipe_len(input int lat);
    return (lat > 0) ? lat - 1 : 0;
  endfunction

  // address width able to express every word
  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/lmem_delay.sv
`timescale 1ns/1ps
module lmem_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[N-1];

endmodule

// File: rtl/lmem_array.sv
`timescale 1ns/1ps
module lmem_array #(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 12,
  parameter int MW    = 2,
  parameter int NRD   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MW-1:0]            we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rword,
  output logic [NRD-1:0]           rok
);

  localparam int LW = DW / MW;
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          w_ok;

  assign w_ok = ({1'b0, waddr} < LIMIT);

  // lane-masked write, dropped when out of range
  always_ff @(posedge clk) begin
    if (!rst && w_ok) begin
      for (int l = 0; l < MW; l++) begin
        if (we[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rok[p]   = ({1'b0, raddr[p]} < LIMIT);
    assign rword[p] = rok[p] ? mem[raddr[p]] : '0;
  end

endmodule

// File: rtl/lmem_rd_stage.sv
`timescale 1ns/1ps
module lmem_rd_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] word,
  input  logic          ok,
  output logic [DW-1:0] q,
  output logic          oob
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      oob <= 1'b0;
    end else if (ld) begin
      q   <= word;
      oob <= !ok;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(q) && $stable(oob)));

  // R4
  oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
    oob |-> (q == '0));

endmodule

// File: rtl/lmem_top.sv
`timescale 1ns/1ps
module lmem_top
  import lmem_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   DEPTH      = 12,
  parameter int   LANE_W     = 4,
  parameter int   RD_LAT     = 2,
  parameter int   WR_LAT     = 2,
  parameter bit   RA_EN_TIED = 1'b0,
  localparam int  AW         = addr_bits(DEPTH),
  localparam int  MW         = lane_cnt(DATA_W, LANE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     ra_addr,
  input  logic              ra_en,
  output logic [DATA_W-1:0] ra_data,
  output logic              ra_oob,
  input  logic [AW-1:0]     sp_addr,
  input  logic              sp_en,
  input  logic              sp_wmode,
  input  logic [DATA_W-1:0] sp_wdata,
  input  logic [MW-1:0]     sp_wmask,
  output logic [DATA_W-1:0] sp_rdata,
  output logic              sp_oob
);

  localparam int RP  = pipe_len(RD_LAT);
  localparam int WP  = WR_LAT - 1;
  localparam int SPW = AW + 2 + DATA_W + MW;
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  // ---------------- read-only port pipeline ----------------
  logic [AW:0]   ra_bus_d;
  logic [AW-1:0] ra_addr_d;
  logic          ra_en_d;
  logic          ra_ld;

  if (RP > 0) begin : g_ra_pipe
    lmem_delay #(.W(AW+1), .N(RP)) u_ra_dly (
      .clk (clk),
      .rst (rst),
      .d   ({ra_addr, ra_en}),
      .q   (ra_bus_d)
    );
  end else begin : g_ra_direct
    assign ra_bus_d = {ra_addr, ra_en};
  end

  assign {ra_addr_d, ra_en_d} = ra_bus_d;
  assign ra_ld = RA_EN_TIED ? 1'b1 : ra_en_d;

  // ---------------- shared port pipeline ----------------
  logic [SPW-1:0]    sp_bus_d;
  logic [AW-1:0]     spd_addr;
  logic              spd_en;
  logic              spd_wmode;
  logic [DATA_W-1:0] spd_wdata;
  logic [MW-1:0]     spd_wmask;
  logic [MW-1:0]     sp_we;
  logic              sp_rld;

  if (WP > 0) begin : g_sp_pipe
    lmem_delay #(.W(SPW), .N(WP)) u_sp_dly (
      .clk (clk),
      .rst (rst),
      .d   ({sp_addr, sp_en, sp_wmode, sp_wdata, sp_wmask}),
      .q   (sp_bus_d)
    );
  end else begin : g_sp_direct
    assign sp_bus_d = {sp_addr, sp_en, sp_wmode, sp_wdata, sp_wmask};
  end

  assign {spd_addr, spd_en, spd_wmode, spd_wdata, spd_wmask} = sp_bus_d;
  assign sp_we  = {MW{spd_en & spd_wmode}} & spd_wmask;
  assign sp_rld = spd_en & ~spd_wmode;

  // ---------------- array ----------------
  logic [1:0][AW-1:0]     rd_addr;
  logic [1:0][DATA_W-1:0] rd_word;
  logic [1:0]             rd_ok;

  assign rd_addr[0] = ra_addr_d;
  assign rd_addr[1] = (RD_LAT > 0) ? spd_addr : sp_addr;

  lmem_array #(
    .DW    (DATA_W),
    .AW    (AW),
    .DEPTH (DEPTH),
    .MW    (MW),
    .NRD   (2)
  ) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (sp_we),
    .waddr (spd_addr),
    .wdata (spd_wdata),
    .raddr (rd_addr),
    .rword (rd_word),
    .rok   (rd_ok)
  );

  // ---------------- read stages ----------------
  if (RD_LAT > 0) begin : g_reg_rd
    lmem_rd_stage #(.DW(DATA_W)) u_ra_stage (
      .clk  (clk),
      .rst  (rst),
      .ld   (ra_ld),
      .word (rd_word[0]),
      .ok   (rd_ok[0]),
      .q    (ra_data),
      .oob  (ra_oob)
    );
    lmem_rd_stage #(.DW(DATA_W)) u_sp_stage (
      .clk  (clk),
      .rst  (rst),
      .ld   (sp_rld),
      .word (rd_word[1]),
      .ok   (rd_ok[1]),
      .q    (sp_rdata),
      .oob  (sp_oob)
    );

    // R10
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!ra_oob && !sp_oob && ra_data == '0 && sp_rdata == '0));
  end else begin : g_comb_rd
    assign ra_data  = rd_word[0];
    assign ra_oob   = !rd_ok[0];
    assign sp_rdata = rd_word[1];
    assign sp_oob   = !rd_ok[1];
  end

  // ---------------- latency checks on flags ----------------
  if (RD_LAT == 1 && !RA_EN_TIED) begin : g_ra_lat1
    // R4
    ra_oob_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (ra_en && ({1'b0, ra_addr} >= LIMIT)) |=> ra_oob);
  end else if (RD_LAT == 2 && !RA_EN_TIED) begin : g_ra_lat2
    // R4
    ra_oob_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (ra_en && ({1'b0, ra_addr} >= LIMIT)) |-> ##2 ra_oob);
  end

  if (RD_LAT > 0 && WR_LAT == 1) begin : g_sp_lat1
    // R7
    sp_oob_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (sp_en && !sp_wmode && ({1'b0, sp_addr} >= LIMIT)) |=> sp_oob);
  end else if (RD_LAT > 0 && WR_LAT == 2) begin : g_sp_lat2
    // R7
    sp_oob_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (sp_en && !sp_wmode && ({1'b0, sp_addr} >= LIMIT)) |-> ##2 sp_oob);
  end

endmodule

// File: tb/sim_lmem_top.sv
`timescale 1ns/1ps
module sim_lmem_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ra_addr = '0;
  logic       ra_en = 1'b0;
  logic [3:0] sp_addr = '0;
  logic       sp_en = 1'b0;
  logic       sp_wmode = 1'b0;
  logic [7:0] sp_wdata = '0;
  logic [1:0] sp_wmask = '0;

  logic [7:0] r0_d, s0_d, r1_d, s1_d, r2_d, s2_d;
  logic       r0_o, s0_o, r1_o, s1_o, r2_o, s2_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  // u0: read latency 2, write latency 2
  lmem_top u0 (
    .clk(clk), .rst(rst), .ra_addr(ra_addr), .ra_en(ra_en),
    .ra_data(r0_d), .ra_oob(r0_o), .sp_addr(sp_addr), .sp_en(sp_en),
    .sp_wmode(sp_wmode), .sp_wdata(sp_wdata), .sp_wmask(sp_wmask),
    .sp_rdata(s0_d), .sp_oob(s0_o)
  );

  // u1: latency 1 / 1, read enable tied high
  lmem_top #(.RD_LAT(1), .WR_LAT(1), .RA_EN_TIED(1'b1)) u1 (
    .clk(clk), .rst(rst), .ra_addr(ra_addr), .ra_en(ra_en),
    .ra_data(r1_d), .ra_oob(r1_o), .sp_addr(sp_addr), .sp_en(sp_en),
    .sp_wmode(sp_wmode), .sp_wdata(sp_wdata), .sp_wmask(sp_wmask),
    .sp_rdata(s1_d), .sp_oob(s1_o)
  );

  // u2: combinational read, write latency 1
  lmem_top #(.RD_LAT(0), .WR_LAT(1)) u2 (
    .clk(clk), .rst(rst), .ra_addr(ra_addr), .ra_en(ra_en),
    .ra_data(r2_d), .ra_oob(r2_o), .sp_addr(sp_addr), .sp_en(sp_en),
    .sp_wmode(sp_wmode), .sp_wdata(sp_wdata), .sp_wmask(sp_wmask),
    .sp_rdata(s2_d), .sp_oob(s2_o)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ra_en = 1'b0; sp_en = 1'b0; sp_wmode = 1'b0; sp_wmask = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sp_write(input logic [3:0] a, input logic [7:0] d, input logic [1:0] m);
    sp_addr = a; sp_wdata = d; sp_wmask = m; sp_en = 1'b1; sp_wmode = 1'b1;
    @(negedge clk);
  endtask

  // read on the read-only port, each copy sampled at its due cycle
  task automatic do_read(input string tag, input logic [3:0] a,
                         input logic [7:0] ed, input logic eo);
    ra_addr = a; ra_en = 1'b1;
    #1;
    chk({tag, " u2 data"}, r2_d, ed);
    chk({tag, " u2 flag"}, {7'd0, r2_o}, {7'd0, eo});
    @(negedge clk);
    chk({tag, " u1 data"}, r1_d, ed);
    chk({tag, " u1 flag"}, {7'd0, r1_o}, {7'd0, eo});
    ra_en = 1'b0;
    @(negedge clk);
    chk({tag, " u0 data"}, r0_d, ed);
    chk({tag, " u0 flag"}, {7'd0, r0_o}, {7'd0, eo});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 u0 ra_data in reset", r0_d, 8'h00);
    chk("R10 u0 sp_rdata in reset", s0_d, 8'h00);
    chk("R10 u0 ra_oob in reset", {7'd0, r0_o}, 8'h00);
    chk("R10 u1 ra_data in reset", r1_d, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_preload;
    for (int i = 0; i < 12; i++) sp_write(4'(i), 8'h30 + 8'(i), 2'b11);
    idle(3);
  endtask

  task automatic t_latency;
    ra_addr = 4'd4; ra_en = 1'b1;
    #1;
    chk("R1 u2 same-cycle read", r2_d, 8'h34);
    @(negedge clk);
    chk("R1 u1 read after one edge", r1_d, 8'h34);
    chk("R1 u0 not yet updated", r0_d, 8'h00);
    ra_en = 1'b0; ra_addr = 4'd7;
    @(negedge clk);
    chk("R1 u0 read after two edges", r0_d, 8'h34);
    chk("R3 u1 loads with enable low", r1_d, 8'h37);
    @(negedge clk);
    chk("R2 u0 holds with enable low", r0_d, 8'h34);
    chk("R2 u0 flag holds", {7'd0, r0_o}, 8'h00);
  endtask

  task automatic t_mask;
    sp_write(4'd2, 8'hCD, 2'b01);
    idle(3);
    do_read("R5 lane0 only", 4'd2, 8'h3D, 1'b0);
    sp_write(4'd2, 8'h9E, 2'b10);
    idle(3);
    do_read("R5 lane1 only", 4'd2, 8'h9D, 1'b0);
  endtask

  task automatic t_no_write;
    sp_addr = 4'd5; sp_wdata = 8'hEE; sp_wmask = 2'b11; sp_en = 1'b1; sp_wmode = 1'b0;
    @(negedge clk);
    sp_addr = 4'd6; sp_en = 1'b0; sp_wmode = 1'b1;
    @(negedge clk);
    idle(3);
    do_read("R6 mode low no write", 4'd5, 8'h35, 1'b0);
    do_read("R6 enable low no write", 4'd6, 8'h36, 1'b0);
  endtask

  task automatic t_sp_read;
    sp_addr = 4'd9; sp_en = 1'b1; sp_wmode = 1'b0;
    #1;
    chk("R7 u2 shared comb read", s2_d, 8'h39);
    @(negedge clk);
    chk("R7 u1 shared read", s1_d, 8'h39);
    chk("R7 u0 shared not yet", s0_d, 8'h35);
    sp_en = 1'b0; sp_addr = 4'd10;
    @(negedge clk);
    chk("R7 u0 shared read", s0_d, 8'h39);
    chk("R7 u1 shared holds", s1_d, 8'h39);
    @(negedge clk);
    chk("R7 u0 shared holds", s0_d, 8'h39);
  endtask

  task automatic t_oob;
    do_read("R4 oob read", 4'd13, 8'h00, 1'b1);
    sp_write(4'd13, 8'h77, 2'b11);
    idle(3);
    do_read("R8 oob write dropped", 4'd13, 8'h00, 1'b1);
    do_read("R8 no alias at 5", 4'd5, 8'h35, 1'b0);
    sp_addr = 4'd15; sp_en = 1'b1; sp_wmode = 1'b0;
    @(negedge clk);
    chk("R4 u1 shared oob flag", {7'd0, s1_o}, 8'h01);
    chk("R4 u1 shared oob data", s1_d, 8'h00);
    idle(1);
    chk("R4 u0 shared oob flag", {7'd0, s0_o}, 8'h01);
  endtask

  task automatic t_collision;
    ra_addr = 4'd3; ra_en = 1'b1;
    sp_addr = 4'd3; sp_wdata = 8'h99; sp_wmask = 2'b11; sp_en = 1'b1; sp_wmode = 1'b1;
    @(negedge clk);
    chk("R9 u1 read-before-write", r1_d, 8'h33);
    ra_en = 1'b0; sp_en = 1'b0; sp_wmode = 1'b0; sp_wmask = '0;
    @(negedge clk);
    chk("R9 u0 read-before-write", r0_d, 8'h33);
    chk("R3 u1 reloads new word", r1_d, 8'h99);
    idle(2);
    do_read("R9 new word visible", 4'd3, 8'h99, 1'b0);
  endtask

  initial begin
    t_reset;
    t_preload;
    t_latency;
    t_mask;
    t_no_write;
    t_sp_read;
    t_oob;
    t_collision;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule